// File: doc/BRIEF.md
# AES Byte Substitution Unit (Composite-Field Arithmetic)

This unit produces the AES forward substitution of one byte per clock without a stored 256-entry table. The incoming byte is carried by a linear change of basis into a tower field, GF(((2^2)^2)^2). There its multiplicative inverse is formed from GF(2^4) products and one GF(2^4) inverse, which itself is built from GF(2^2) operations. The result is carried back to the standard byte basis. The return map and the AES affine matrix are folded into one 8x8 binary matrix, followed by the constant 0x63.

The unit fits compact cipher cores that run one substitution per cycle, or a few in parallel, and want to avoid ROM area. A parameter `OutReg` chooses between two forms of the unit. In one form it is purely combinational. In the other it has one output register, and a valid flag is delayed together with the data. The basis-change matrices are not written out by hand. They are derived while the design elaborates: a constant function finds a root of the AES field polynomial inside the tower field, and from that root it builds the matrix and its inverse.

Top module: `aesSubByte`

## Requirements
- R1: For every one of the 256 input bytes, the output equals the AES forward S-box value, defined as the GF(2^8) inverse modulo x^8+x^4+x^3+x+1 (with 0 taken as its own inverse) followed by the AES affine map with constant 0x63.
- R2: Input 0x00 produces output 0x63.
- R3: Spot values hold: 0x01 gives 0x7C, 0x53 gives 0xED, 0xFF gives 0x16, 0x80 gives 0xCD.
- R4: No input maps to itself, and no input maps to its bitwise complement.
- R5: With `OutReg`=1, `outByte` and `outValid` reflect the input one rising clock edge after it is presented, and an active-low `rstN` clears both to 0.
- R6: With `OutReg`=0, `outByte` follows `inByte` in the same cycle and `outValid` equals `inValid`.
- R7: With `OutReg`=1, while `inValid` is low the output register keeps its last result and `outValid` reads 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Active-low synchronous reset of the output stage |
| inValid | input | 1 | Marks `inByte` as carrying a byte to substitute |
| inByte | input | 8 | Byte to substitute |
| outValid | output | 1 | Marks `outByte` as holding a result |
| outByte | output | 8 | Substituted byte |

## Verification
The bench goes after the zero input first. Here the composite-field inverse has to collapse to zero through a zero norm. A design that mishandled it would emit something other than 0x63, or an inverse of garbage. The full 256-value sweep and the spot values catch a wrong basis matrix or a wrong tower constant. Such a design still maps zero correctly but corrupts almost every other byte. Gaps in `inValid` check the registered form: a register that loaded on every cycle would overwrite the held result, and a valid stage with the wrong delay would line `outValid` up against the wrong data.

// File: rtl/subBytePkg.sv
package subBytePkg;

  localparam int ByteW = 8;
  localparam int NibW  = ByteW / 2;
  localparam int PairW = NibW / 2;
  localparam int FieldSize = 1 << ByteW;
  localparam int NibSize   = 1 << NibW;
  localparam logic [ByteW-1:0] AffConst = 8'h63;
  localparam logic [PairW-1:0] Phi = 2'b10;

  typedef logic [ByteW-1:0][ByteW-1:0] mat8_t;

  typedef struct packed {
    logic capture;
  } subByteStrobe_t;

  function automatic logic [PairW-1:0] gf4Mul(logic [PairW-1:0] a, logic [PairW-1:0] b);
    logic hi, lo;
    hi = (a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]);
    lo = (a[1] & b[1]) ^ (a[0] & b[0]);
    return {hi, lo};
  endfunction

  function automatic logic [PairW-1:0] gf4Sq(logic [PairW-1:0] a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  function automatic logic [NibW-1:0] gf16Mul(logic [NibW-1:0] a, logic [NibW-1:0] b);
    logic [PairW-1:0] p11, hi, lo;
    p11 = gf4Mul(a[3:2], b[3:2]);
    hi  = p11 ^ gf4Mul(a[3:2], b[1:0]) ^ gf4Mul(a[1:0], b[3:2]);
    lo  = gf4Mul(p11, Phi) ^ gf4Mul(a[1:0], b[1:0]);
    return {hi, lo};
  endfunction

  function automatic logic [NibW-1:0] gf16Inv(logic [NibW-1:0] a);
    logic [PairW-1:0] norm, normInv;
    norm    = gf4Mul(gf4Sq(a[3:2]), Phi) ^ gf4Mul(a[3:2], a[1:0]) ^ gf4Sq(a[1:0]);
    normInv = gf4Sq(norm);
    return {gf4Mul(a[3:2], normInv), gf4Mul(a[3:2] ^ a[1:0], normInv)};
  endfunction

  function automatic logic [ByteW-1:0] towerMul(logic [ByteW-1:0] a, logic [ByteW-1:0] b,
                                                logic [NibW-1:0] lam);
    logic [NibW-1:0] p11, hi, lo;
    p11 = gf16Mul(a[7:4], b[7:4]);
    hi  = p11 ^ gf16Mul(a[7:4], b[3:0]) ^ gf16Mul(a[3:0], b[7:4]);
    lo  = gf16Mul(p11, lam) ^ gf16Mul(a[3:0], b[3:0]);
    return {hi, lo};
  endfunction

  function automatic logic [NibW-1:0] findLambda();
    logic [NibW-1:0] pick;
    logic found;
    pick  = '0;
    found = 1'b0;
    for (int c = 1; c < NibSize; c++) begin
      logic hit;
      hit = 1'b0;
      for (int s = 0; s < NibSize; s++) begin
        if ((gf16Mul(NibW'(s), NibW'(s)) ^ NibW'(s)) == NibW'(c)) hit = 1'b1;
      end
      if (!hit && !found) begin
        pick  = NibW'(c);
        found = 1'b1;
      end
    end
    return pick;
  endfunction

  function automatic logic [ByteW-1:0] findRoot(logic [NibW-1:0] lam);
    logic [ByteW-1:0] pick;
    logic found;
    pick  = '0;
    found = 1'b0;
    for (int c = 2; c < FieldSize; c++) begin
      logic [ByteW-1:0] p1, p2, p3, p4, p8, poly;
      p1   = ByteW'(c);
      p2   = towerMul(p1, p1, lam);
      p3   = towerMul(p2, p1, lam);
      p4   = towerMul(p2, p2, lam);
      p8   = towerMul(p4, p4, lam);
      poly = p8 ^ p4 ^ p3 ^ p1 ^ 8'h01;
      if (poly == '0 && !found) begin
        pick  = p1;
        found = 1'b1;
      end
    end
    return pick;
  endfunction

  function automatic logic [ByteW-1:0] linApply(mat8_t cols, logic [ByteW-1:0] v);
    logic [ByteW-1:0] acc;
    acc = '0;
    for (int i = 0; i < ByteW; i++) begin
      if (v[i]) acc = acc ^ cols[i];
    end
    return acc;
  endfunction

  function automatic mat8_t buildMapIn(logic [NibW-1:0] lam);
    mat8_t cols;
    logic [ByteW-1:0] root, pw;
    root = findRoot(lam);
    pw   = 8'h01;
    for (int i = 0; i < ByteW; i++) begin
      cols[i] = pw;
      pw = towerMul(pw, root, lam);
    end
    return cols;
  endfunction

  function automatic logic [ByteW-1:0] affLinear(logic [ByteW-1:0] b);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]};
  endfunction

  function automatic mat8_t buildMapOut(mat8_t mapIn);
    mat8_t cols;
    cols = '0;
    for (int j = 0; j < ByteW; j++) begin
      for (int y = 0; y < FieldSize; y++) begin
        if (linApply(mapIn, ByteW'(y)) == ByteW'(1 << j)) cols[j] = affLinear(ByteW'(y));
      end
    end
    return cols;
  endfunction

endpackage

// File: rtl/subByteCtrl.sv
module subByteCtrl
  import subBytePkg::*;
#(
  parameter bit OutReg = 1'b1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  output subByteStrobe_t stb,
  output logic           outValid
);

  assign stb.capture = inValid;

  generate
    if (OutReg) begin : gValidReg
      logic validQ;
      always_ff @(posedge clk) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign outValid = validQ;
    end else begin : gValidPass
      assign outValid = inValid;
    end
  endgenerate

endmodule

// File: rtl/subByteDatapath.sv
module subByteDatapath
  import subBytePkg::*;
#(
  parameter bit OutReg = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  subByteStrobe_t   stb,
  input  logic [ByteW-1:0] inByte,
  output logic [ByteW-1:0] outByte
);

  localparam logic [NibW-1:0] Lambda = findLambda();
  localparam mat8_t MapIn  = buildMapIn(Lambda);
  localparam mat8_t MapOut = buildMapOut(MapIn);

  logic [ByteW-1:0] towerVal;
  logic [NibW-1:0]  hiNib, loNib, norm, normInv, invHi, invLo;
  logic [ByteW-1:0] subVal;

  always_comb begin
    towerVal = linApply(MapIn, inByte);
    hiNib    = towerVal[ByteW-1:NibW];
    loNib    = towerVal[NibW-1:0];
    norm     = gf16Mul(gf16Mul(hiNib, hiNib), Lambda)
             ^ gf16Mul(hiNib, loNib)
             ^ gf16Mul(loNib, loNib);
    normInv  = gf16Inv(norm);
    invHi    = gf16Mul(hiNib, normInv);
    invLo    = gf16Mul(hiNib ^ loNib, normInv);
    subVal   = linApply(MapOut, {invHi, invLo}) ^ AffConst;
  end

  generate
    if (OutReg) begin : gDataReg
      logic [ByteW-1:0] dataQ;
      always_ff @(posedge clk) begin
        if (!rstN)            dataQ <= '0;
        else if (stb.capture) dataQ <= subVal;
      end
      assign outByte = dataQ;
    end else begin : gDataPass
      assign outByte = subVal;
    end
  endgenerate

endmodule

// File: rtl/aesSubByte.sv
module aesSubByte
  import subBytePkg::*;
#(
  parameter bit OutReg = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inByte,
  output logic       outValid,
  output logic [7:0] outByte
);

  subByteStrobe_t stb;

  subByteCtrl #(.OutReg(OutReg)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  subByteDatapath #(.OutReg(OutReg)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .inByte  (inByte),
    .outByte (outByte)
  );

endmodule

// File: rtl/aesSubByteChecker.sv
module aesSubByteChecker #(
  parameter bit OutReg = 1'b1
) (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic [7:0] inByte,
  input logic       outValid,
  input logic [7:0] outByte
);

  generate
    if (OutReg) begin : gRegChecks
      a_r2_zero_to_63: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && inByte == 8'h00) |=> (outByte == 8'h63));
      a_r3_one_to_7c: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && inByte == 8'h01) |=> (outByte == 8'h7C));
      a_r4_no_fixed_point: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> (outByte != $past(inByte) && outByte != ~$past(inByte)));
      a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);
      a_r7_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid);
      a_r7_hold_data: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> $stable(outByte));
    end else begin : gCombChecks
      a_r2_zero_to_63: assert property (@(posedge clk) disable iff (!rstN)
        (inByte == 8'h00) |-> (outByte == 8'h63));
      a_r3_one_to_7c: assert property (@(posedge clk) disable iff (!rstN)
        (inByte == 8'h01) |-> (outByte == 8'h7C));
      a_r4_no_fixed_point: assert property (@(posedge clk) disable iff (!rstN)
        inValid |-> (outByte != inByte && outByte != ~inByte));
      a_r6_stable_through: assert property (@(posedge clk) disable iff (!rstN)
        $stable(inByte) |-> $stable(outByte));
    end
  endgenerate

endmodule

bind aesSubByte aesSubByteChecker #(.OutReg(OutReg)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inByte   (inByte),
  .outValid (outValid),
  .outByte  (outByte)
);

// File: tb/sim_aesSubByte.sv
module sim_aesSubByte;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic       outValid, combValid;
  logic [7:0] outByte, combByte;
  int errors = 0;
  int checks = 0;
  logic [7:0] refTab [256];

  always #10 clk = ~clk;

  aesSubByte #(.OutReg(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .outValid(outValid), .outByte(outByte)
  );

  aesSubByte #(.OutReg(1'b0)) uComb (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .outValid(combValid), .outByte(combByte)
  );

  function automatic logic [7:0] aesMul(logic [7:0] a, logic [7:0] b);
    logic [7:0] acc = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return acc;
  endfunction

  function automatic logic [7:0] refSub(logic [7:0] v);
    logic [7:0] inv = 8'h00;
    logic [7:0] s;
    for (int c = 1; c < 256; c++) begin
      if (aesMul(v, 8'(c)) == 8'h01) inv = 8'(c);
    end
    s = inv;
    for (int k = 1; k <= 4; k++) s ^= (inv << k) | (inv >> (8 - k));
    return s ^ 8'h63;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present a byte at negedge; check the combinational copy, then the registered copy after the edge.
  task automatic apply(logic v, logic [7:0] b, string req);
    logic [7:0] heldByte;
    @(negedge clk);
    heldByte = outByte;
    inValid = v;
    inByte = b;
    #2;
    check({req, " R6 comb valid"}, 32'(combValid), 32'(v));
    if (v) check({req, " R6 comb data"}, 32'(combByte), 32'(refTab[b]));
    @(posedge clk);
    #2;
    check({req, " R5 reg valid"}, 32'(outValid), 32'(v));
    if (v) check({req, " R5 reg data"}, 32'(outByte), 32'(refTab[b]));
    else   check({req, " R7 held data"}, 32'(outByte), 32'(heldByte));
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) refTab[i] = refSub(8'(i));

    inValid = 1'b1;
    inByte = 8'h5A;
    repeat (3) @(posedge clk);
    #2;
    check("R5 reset valid", 32'(outValid), 32'd0);
    check("R5 reset data", 32'(outByte), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    inValid = 1'b0;

    check("R3 ref 01", 32'(refTab[8'h01]), 32'h7C);

    apply(1'b1, 8'h00, "R2 zero");
    check("R2 zero out", 32'(outByte), 32'h63);
    apply(1'b1, 8'h01, "R3 one");
    check("R3 one out", 32'(outByte), 32'h7C);
    apply(1'b1, 8'h53, "R3 53");
    check("R3 53 out", 32'(outByte), 32'hED);
    apply(1'b1, 8'hFF, "R3 ff");
    check("R3 ff out", 32'(outByte), 32'h16);
    apply(1'b1, 8'h80, "R3 80");
    check("R3 80 out", 32'(outByte), 32'hCD);
    apply(1'b0, 8'h00, "R7 gap");

    for (int v = 0; v < 256; v++) begin
      apply(1'b1, 8'(v), "R1 sweep");
      check("R4 not fixed", 32'(outByte == 8'(v) || outByte == ~8'(v)), 32'd0);
    end

    void'($urandom(32'd4711));
    for (int n = 0; n < 300; n++) begin
      logic [7:0] rb;
      rb = 8'($urandom % 256);
      apply(($urandom % 4) != 0, rb, "R1 R7 random");
    end

    apply(1'b0, 8'h3C, "R7 final gap");
    apply(1'b0, 8'hC3, "R7 second gap");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule